// File: doc/BRIEF.md
# Signed Memory Map Region Decoder

This block sorts a cell address from a word-addressed memory of N cells into one of eight regions and reports where the address falls inside that region. The address is treated as a two's complement number. Non-negative values select ordinary program and data space. Negative values select an I/O map in the upper half of the memory, and that map is laid out from both of its ends.

The part of the I/O map that starts at the middle of memory holds three read-only geometry cells: screen width, screen height and cells per pixel. Video memory follows them, and a set of block-transfer registers comes after video memory. Because video memory is W*H*C cells long, the start of the block registers moves whenever the screen geometry changes. The part of the I/O map at the top of memory holds the serial data cell at -1, the serial port select at -2, and a timer vector area below them. The timer area holds T vectors, and each vector is S+2 cells. Any cells left between the two parts are unused.

A bus front end uses the block to steer an access. It passes the address in together with the current geometry. One cycle later it receives a one-hot select, the offset inside the chosen region, and, for the geometry cells, the value the cell reads back.

Top module: `mmap_region_dec`

## Requirements
- R1: Each valid result drives exactly one bit of `region_o`. The bit positions are: 0 program, 1 geometry cell, 2 video memory, 3 block register, 4 unused, 5 timer vector, 6 serial port select, 7 serial data.
- R2: An address whose top bit is 0 selects program space (bit 0), and the offset equals the address.
- R3: Addresses -N/2, -N/2+1 and -N/2+2 select the geometry cells (bit 1) with offsets 0, 1 and 2. `rdata_o` returns width, height and cells per pixel for offsets 0, 1 and 2 respectively. For every other region `rdata_o` is 0.
- R4: Video memory (bit 2) covers W*H*C cells starting at -N/2+3. The offset is counted from -N/2+3.
- R5: The block registers (bit 3) start at BK = -N/2+3+W*H*C and span S+3 cells. Offset 0 is the port number, offset 1 is the buffer size, offsets 2 to S+1 are the buffer address, and offset S+2 is the trigger.
- R6: The timer area (bit 5) covers the (S+2)*T cells from -2-(S+2)*T up to -3. The offset is counted from the lowest cell of the area.
- R7: Address -2 selects the serial port cell (bit 6) and address -1 selects the serial data cell (bit 7), both with offset 0.
- R8: Any other negative address lies between the end of the block registers and the timer area and selects unused (bit 4). The offset is counted from BK+S+3.
- R9: `overlap_o` is 1 exactly when the block registers reach into the timer area, that is, when BK+S+3 > -2-(S+2)*T. The precedence among regions is serial cells first, then geometry cells, then timer vectors, then video memory, then block registers.
- R10: Results appear one cycle after `valid_i`, and `valid_o` follows `valid_i` one cycle later. When `valid_i` is low, `region_o`, `offset_o` and `rdata_o` keep their last values. Reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Address is present |
| addr_i | input | ADDR_W | Cell address, two's complement |
| addr_cells_i | input | S_W | Cells per address, S |
| scr_w_i | input | DATA_W | Screen width, W |
| scr_h_i | input | DATA_W | Screen height, H |
| pix_cells_i | input | DATA_W | Cells per pixel, C |
| tmr_cnt_i | input | T_W | Number of timer vectors, T |
| valid_o | output | 1 | Result is present |
| region_o | output | 8 | One-hot region select |
| offset_o | output | ADDR_W | Offset inside the region |
| rdata_o | output | DATA_W | Geometry cell read value |
| overlap_o | output | 1 | Block registers run into the timer area |

## Verification
The assertions assume that the geometry inputs hold steady from the cycle an address is accepted until its result comes out. They also assume that `valid_i` stays low during reset. The bench changes the geometry only while `valid_i` is low and then waits idle cycles before it sends more addresses. It sweeps every address under three geometries: a small layout with a gap between the two parts of the map, a layout where the video memory and the block registers run into the timer area, and an empty layout where W*H*C and T are both zero.

// File: rtl/mmap_region_pkg.sv
package mmap_region_pkg;
  localparam int NREG = 8;
  typedef enum int unsigned {
    RG_PROG   = 0,
    RG_GEOM   = 1,
    RG_VMEM   = 2,
    RG_BLK    = 3,
    RG_FREE   = 4,
    RG_TMR    = 5,
    RG_SPORT  = 6,
    RG_SDATA  = 7
  } region_e;
endpackage

// File: rtl/mmap_geom.sv
module mmap_geom #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16,
  parameter int S_W    = 4,
  parameter int T_W    = 6,
  parameter int GW     = 3 * DATA_W + 4
) (
  input  logic [S_W-1:0]    addr_cells_i,
  input  logic [DATA_W-1:0] scr_w_i,
  input  logic [DATA_W-1:0] scr_h_i,
  input  logic [DATA_W-1:0] pix_cells_i,
  input  logic [T_W-1:0]    tmr_cnt_i,
  output logic [GW-1:0]     vmem_end_o,
  output logic [GW-1:0]     blk_end_o,
  output logic [GW-1:0]     tmr_span_o,
  output logic              overlap_o
);
  localparam logic [GW-1:0] HALF_G = GW'(2 ** (ADDR_W - 1));

  logic [GW-1:0] vlen;

  // positions are relative to -N/2
  assign vlen       = GW'(scr_w_i) * GW'(scr_h_i) * GW'(pix_cells_i);
  assign vmem_end_o = vlen + GW'(3);
  assign blk_end_o  = vmem_end_o + GW'(3) + GW'(addr_cells_i);
  assign tmr_span_o = (GW'(addr_cells_i) + GW'(2)) * GW'(tmr_cnt_i);
  // blk_end > HALF-2-span, kept free of signed arithmetic
  assign overlap_o  = (blk_end_o + tmr_span_o + GW'(2)) > HALF_G;
endmodule

// File: rtl/mmap_classify.sv
module mmap_classify
  import mmap_region_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16,
  parameter int GW     = 3 * DATA_W + 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] scr_w_i,
  input  logic [DATA_W-1:0] scr_h_i,
  input  logic [DATA_W-1:0] pix_cells_i,
  input  logic [GW-1:0]     vmem_end_i,
  input  logic [GW-1:0]     blk_end_i,
  input  logic [GW-1:0]     tmr_span_i,
  output logic [NREG-1:0]   region_o,
  output logic [ADDR_W-1:0] offset_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam logic [GW-1:0] HALF_G = GW'(2 ** (ADDR_W - 1));

  logic [GW-1:0] q;
  logic [GW-1:0] tmr_rel;

  assign q       = GW'(addr_i[ADDR_W-2:0]);
  assign tmr_rel = q + tmr_span_i + GW'(2);

  always_comb begin
    region_o = '0;
    offset_o = '0;
    rdata_o  = '0;
    if (!addr_i[ADDR_W-1]) begin
      region_o[RG_PROG] = 1'b1;
      offset_o = addr_i;
    end else if (q == HALF_G - GW'(1)) begin
      region_o[RG_SDATA] = 1'b1;
    end else if (q == HALF_G - GW'(2)) begin
      region_o[RG_SPORT] = 1'b1;
    end else if (q < GW'(3)) begin
      region_o[RG_GEOM] = 1'b1;
      offset_o = ADDR_W'(q);
      case (q[1:0])
        2'd0:    rdata_o = scr_w_i;
        2'd1:    rdata_o = scr_h_i;
        default: rdata_o = pix_cells_i;
      endcase
    end else if (tmr_rel >= HALF_G) begin
      region_o[RG_TMR] = 1'b1;
      offset_o = ADDR_W'(tmr_rel - HALF_G);
    end else if (q < vmem_end_i) begin
      region_o[RG_VMEM] = 1'b1;
      offset_o = ADDR_W'(q - GW'(3));
    end else if (q < blk_end_i) begin
      region_o[RG_BLK] = 1'b1;
      offset_o = ADDR_W'(q - vmem_end_i);
    end else begin
      region_o[RG_FREE] = 1'b1;
      offset_o = ADDR_W'(q - blk_end_i);
    end
  end
endmodule

// File: rtl/mmap_region_dec.sv
module mmap_region_dec
  import mmap_region_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16,
  parameter int S_W    = 4,
  parameter int T_W    = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [S_W-1:0]    addr_cells_i,
  input  logic [DATA_W-1:0] scr_w_i,
  input  logic [DATA_W-1:0] scr_h_i,
  input  logic [DATA_W-1:0] pix_cells_i,
  input  logic [T_W-1:0]    tmr_cnt_i,
  output logic              valid_o,
  output logic [NREG-1:0]   region_o,
  output logic [ADDR_W-1:0] offset_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              overlap_o
);
  localparam int GW = 3 * DATA_W + 4;

  logic [GW-1:0]     vmem_end, blk_end, tmr_span;
  logic              overlap_d;
  logic [NREG-1:0]   region_d;
  logic [ADDR_W-1:0] offset_d;
  logic [DATA_W-1:0] rdata_d;

  mmap_geom #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .S_W(S_W), .T_W(T_W), .GW(GW)
  ) u_geom (
    .addr_cells_i(addr_cells_i),
    .scr_w_i     (scr_w_i),
    .scr_h_i     (scr_h_i),
    .pix_cells_i (pix_cells_i),
    .tmr_cnt_i   (tmr_cnt_i),
    .vmem_end_o  (vmem_end),
    .blk_end_o   (blk_end),
    .tmr_span_o  (tmr_span),
    .overlap_o   (overlap_d)
  );

  mmap_classify #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .GW(GW)
  ) u_cls (
    .addr_i     (addr_i),
    .scr_w_i    (scr_w_i),
    .scr_h_i    (scr_h_i),
    .pix_cells_i(pix_cells_i),
    .vmem_end_i (vmem_end),
    .blk_end_i  (blk_end),
    .tmr_span_i (tmr_span),
    .region_o   (region_d),
    .offset_o   (offset_d),
    .rdata_o    (rdata_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      region_o  <= '0;
      offset_o  <= '0;
      rdata_o   <= '0;
      overlap_o <= 1'b0;
    end else begin
      valid_o   <= valid_i;
      overlap_o <= overlap_d;
      if (valid_i) begin
        region_o <= region_d;
        offset_o <= offset_d;
        rdata_o  <= rdata_d;
      end
    end
  end

  a_r1_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $onehot(region_o));

  a_r2_program: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !addr_i[ADDR_W-1] |=> region_o[RG_PROG] && offset_o == $past(addr_i));

  a_r3_rdata_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !region_o[RG_GEOM] |-> rdata_o == '0);

  a_r7_serial_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && addr_i == '1 |=> region_o[RG_SDATA] && offset_o == '0);

  a_r9_geom_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && addr_i[ADDR_W-1] && addr_i[ADDR_W-2:0] < 3 |=> region_o[RG_GEOM]);

  a_r10_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o && $stable(region_o) && $stable(offset_o) && $stable(rdata_o));
endmodule

// File: tb/tb_mmap_region_dec.sv
module tb_mmap_region_dec;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 16;
  localparam int S_W    = 4;
  localparam int T_W    = 6;
  localparam int NCELL  = 2 ** ADDR_W;
  localparam int HALF   = NCELL / 2;

  typedef struct {
    int addr;
    int rg;
    int off;
    int rd;
  } exp_t;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              valid_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [S_W-1:0]    addr_cells_i = '0;
  logic [DATA_W-1:0] scr_w_i = '0, scr_h_i = '0, pix_cells_i = '0;
  logic [T_W-1:0]    tmr_cnt_i = '0;
  logic              valid_o;
  logic [7:0]        region_o;
  logic [ADDR_W-1:0] offset_o;
  logic [DATA_W-1:0] rdata_o;
  logic              overlap_o;

  int n_chk = 0, n_fail = 0;
  int c_w, c_h, c_c, c_s, c_t;
  exp_t sb[$];
  string tags[8] = '{"R2", "R3", "R4", "R5", "R8", "R6", "R7", "R7"};

  always #2 clk = ~clk;

  mmap_region_dec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .S_W(S_W), .T_W(T_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .addr_i(addr_i),
    .addr_cells_i(addr_cells_i), .scr_w_i(scr_w_i), .scr_h_i(scr_h_i),
    .pix_cells_i(pix_cells_i), .tmr_cnt_i(tmr_cnt_i), .valid_o(valid_o),
    .region_o(region_o), .offset_o(offset_o), .rdata_o(rdata_o), .overlap_o(overlap_o)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // expected result, from the layout rules alone
  function automatic exp_t model(input int a);
    exp_t e;
    int rel, vm_lo, vm_n, bk, tm_lo;
    e.addr = a; e.rd = 0;
    rel   = a - HALF;                 // distance above -N/2 for negative codes
    vm_lo = 3;
    vm_n  = c_w * c_h * c_c;
    bk    = vm_lo + vm_n;
    tm_lo = HALF - 2 - (c_s + 2) * c_t;
    if (a < HALF) begin e.rg = 0; e.off = a; end
    else if (a == NCELL - 1) begin e.rg = 7; e.off = 0; end
    else if (a == NCELL - 2) begin e.rg = 6; e.off = 0; end
    else if (rel <= 2) begin
      e.rg = 1; e.off = rel;
      e.rd = (rel == 0) ? c_w : (rel == 1) ? c_h : c_c;
    end
    else if (rel >= tm_lo) begin e.rg = 5; e.off = rel - tm_lo; end
    else if (rel < bk) begin e.rg = 2; e.off = rel - vm_lo; end
    else if (rel < bk + c_s + 3) begin e.rg = 3; e.off = rel - bk; end
    else begin e.rg = 4; e.off = rel - (bk + c_s + 3); end
    return e;
  endfunction

  task automatic send(input int a);
    @(negedge clk);
    addr_i  = ADDR_W'(a);
    valid_i = 1'b1;
    sb.push_back(model(a));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid_i = 1'b0;
    end
  endtask

  task automatic set_cfg(input int w, input int h, input int c, input int s, input int t);
    idle(1);
    c_w = w; c_h = h; c_c = c; c_s = s; c_t = t;
    scr_w_i = DATA_W'(w); scr_h_i = DATA_W'(h); pix_cells_i = DATA_W'(c);
    addr_cells_i = S_W'(s); tmr_cnt_i = T_W'(t);
    idle(2);
  endtask

  always @(negedge clk) begin
    if (rst_ni && valid_o) begin
      if (sb.size() == 0) begin
        check("R10 unexpected valid_o", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check($sformatf("R1/%s region addr=%0d", tags[e.rg], e.addr), int'(region_o), 1 << e.rg);
        check($sformatf("%s offset addr=%0d", tags[e.rg], e.addr), int'(offset_o), e.off);
        check($sformatf("R3 rdata addr=%0d", e.addr), int'(rdata_o), e.rd);
      end
    end
  end

  task automatic summary;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog R10 actual=hung expected=done");
    summary();
  end

  initial begin
    c_w = 0; c_h = 0; c_c = 0; c_s = 0; c_t = 0;
    repeat (3) @(negedge clk);
    check("R10 reset valid_o", int'(valid_o), 0);
    check("R10 reset region_o", int'(region_o), 0);
    check("R10 reset offset_o", int'(offset_o), 0);
    check("R10 reset overlap_o", int'(overlap_o), 0);
    rst_ni = 1'b1;

    // small layout with a gap
    set_cfg(4, 3, 2, 2, 3);
    check("R9 no overlap", int'(overlap_o), 0);
    for (int a = 0; a < NCELL; a++) send(a);
    idle(3);

    // R10: hold while idle
    send(5);
    @(negedge clk);
    valid_i = 1'b0;
    addr_i  = '1;
    @(negedge clk);
    check("R10 valid_o low", int'(valid_o), 0);
    check("R10 region held", int'(region_o), 1);
    check("R10 offset held", int'(offset_o), 5);

    // large layout overlapping timers (R9 precedence)
    set_cfg(40, 25, 2, 2, 15);
    check("R9 overlap", int'(overlap_o), 1);
    for (int a = 0; a < NCELL; a++) send(a);
    idle(3);

    // empty layout
    set_cfg(0, 0, 0, 0, 0);
    check("R9 no overlap empty", int'(overlap_o), 0);
    for (int a = 0; a < NCELL; a++) send(a);
    idle(3);
    check("R10 scoreboard drained", sb.size(), 0);
    summary();
  end
endmodule